// File: doc/BRIEF.md
# Gated PWM Generator with Dual Constants

This block drives one pulse-width-modulated output from a counter of configurable width. One constant sets the length of the active phase and a second the length of the inactive phase, both counted in ticks. A second pair of constants is held in reserve. A select input chooses between the two pairs, and the block can change pairs without stopping. The new pair takes effect at the start of the next active phase, so no phase is ever cut short or stretched.

A tick comes from one of two sources. The first is an internal prescaler that divides the system clock by a power of two chosen by a 3-bit selector. The second is the rising edge of an external clock, which the block synchronizes to its own clock. A one-cycle start pulse begins the waveform, and a one-cycle halt pulse ends it. An optional gate input pauses the waveform, with its sense set by a two-bit field. The active output level can be set either way.

Top module: `gated_pwm`

## Requirements
- R1: Out of reset the block is halted, and `pwm_out` sits at the inactive level, which is the inverse of `out_pol`.
- R2: In the clock cycle after a `start` pulse, `pwm_out` goes to the active level. It stays active for `max(A,1)` ticks, then goes inactive for `max(B,1)` ticks, and the pattern repeats.
- R3: When `tick_src`=0, a tick occurs once every 2^`div_sel` clock cycles while the block runs. Each phase therefore lasts its constant times 2^`div_sel` cycles.
- R4: A constant of zero gives a phase of exactly one tick.
- R5: When `out_pol`=1 the active level is high, and when `out_pol`=0 it is low.
- R6: A `halt` pulse drives the output inactive from the next cycle on. If `halt` and `start` arrive in the same cycle, `halt` wins. A later `start` restarts the pattern at the beginning of the active phase.
- R7: When `gate_pol`=01, a high `gate_in` forces the output inactive in the same cycle and freezes the count. A low `gate_in` lets the pattern resume where it stopped.
- R8: When `gate_pol`=10, a low `gate_in` forces the output inactive and freezes the count. A high `gate_in` lets the pattern run.
- R9: When `gate_pol` is 00 or 11, `gate_in` has no effect.
- R10: The block reads `alt_sel` at each start and at each change from inactive to active. The value 1 selects the pair `const_a2`/`const_b2`, and 0 selects `const_a`/`const_b`. A change of `alt_sel` at any other time takes effect at the next active phase.
- R11: When `tick_src`=1, each rising edge of `ext_clk` gives exactly one tick. Without edges, the pattern does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle start pulse |
| halt | input | 1 | One-cycle halt pulse; takes priority over start |
| out_pol | input | 1 | 1: active level is high; 0: active level is low |
| gate_pol | input | 2 | Gate sense: 01 low enables, 10 high enables, 00/11 gate ignored |
| gate_in | input | 1 | Gate input, synchronous to clk |
| tick_src | input | 1 | 0: internal prescaler; 1: ext_clk rising edges |
| div_sel | input | DIV_W | Prescaler divide by 2^div_sel |
| ext_clk | input | 1 | External tick source, asynchronous |
| alt_sel | input | 1 | 1 selects the alternate constant pair |
| const_a | input | CNT_W | Active-phase length, primary pair |
| const_b | input | CNT_W | Inactive-phase length, primary pair |
| const_a2 | input | CNT_W | Active-phase length, alternate pair |
| const_b2 | input | CNT_W | Inactive-phase length, alternate pair |
| pwm_out | output | 1 | PWM output |

## Verification
The properties assume that `gate_in` is already synchronous to `clk`, and that `out_pol` and `gate_pol` only change while the block is halted or when a check accounts for the change. The bench changes every input just after the falling clock edge. It sets up the configuration before each start pulse, and the only things it changes mid-pattern are `gate_in` and `alt_sel`. Each `ext_clk` level is held for several clock cycles, so the synchronizer sees every edge exactly once.

// File: rtl/gated_pwm.sv
module gated_pwm #(
  parameter int CNT_W = 32,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             halt,
  input  logic             out_pol,
  input  logic [1:0]       gate_pol,
  input  logic             gate_in,
  input  logic             tick_src,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             ext_clk,
  input  logic             alt_sel,
  input  logic [CNT_W-1:0] const_a,
  input  logic [CNT_W-1:0] const_b,
  input  logic [CNT_W-1:0] const_a2,
  input  logic [CNT_W-1:0] const_b2,
  output logic             pwm_out
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic             run;
  logic             ph_act;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lat_a;
  logic [CNT_W-1:0] lat_b;
  logic [PRE_W-1:0] pre;
  logic [2:0]       ext_q;

  logic             gate_ok;
  logic             en;
  logic [PRE_W-1:0] mask;
  logic             tick;
  logic [CNT_W-1:0] sel_a;
  logic [CNT_W-1:0] sel_b;
  logic [CNT_W-1:0] len;
  logic             last;

  assign gate_ok = (gate_pol == 2'b01) ? ~gate_in :
                   (gate_pol == 2'b10) ?  gate_in : 1'b1;
  assign en      = run & gate_ok;
  assign mask    = (PRE_W'(1) << div_sel) - PRE_W'(1);
  assign tick    = tick_src ? (ext_q[1] & ~ext_q[2]) : ((pre & mask) == mask);
  assign sel_a   = alt_sel ? const_a2 : const_a;
  assign sel_b   = alt_sel ? const_b2 : const_b;
  assign len     = ph_act ? lat_a : lat_b;
  assign last    = ({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, len};
  assign pwm_out = (en & ph_act) ? out_pol : ~out_pol;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= {ext_q[1:0], ext_clk};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      ph_act <= 1'b0;
      cnt    <= '0;
      pre    <= '0;
      lat_a  <= '0;
      lat_b  <= '0;
    end else if (halt) begin
      run <= 1'b0;
    end else if (start) begin
      run    <= 1'b1;
      ph_act <= 1'b1;
      cnt    <= '0;
      pre    <= '0;
      lat_a  <= sel_a;
      lat_b  <= sel_b;
    end else if (en) begin
      pre <= pre + PRE_W'(1);
      if (tick) begin
        if (last) begin
          cnt    <= '0;
          ph_act <= ~ph_act;
          if (!ph_act) begin
            lat_a <= sel_a;
            lat_b <= sel_b;
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

module gated_pwm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       halt,
  input logic       out_pol,
  input logic [1:0] gate_pol,
  input logic       gate_in,
  input logic       pwm_out
);
  assert_halt_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (pwm_out == ~out_pol));

  assert_gate_low_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_pol == 2'b01 && gate_in) |-> (pwm_out == ~out_pol));

  assert_gate_high_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_pol == 2'b10 && !gate_in) |-> (pwm_out == ~out_pol));

  assert_start_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !halt && (gate_pol == 2'b00 || gate_pol == 2'b11)) |=> (pwm_out == out_pol));
endmodule

bind gated_pwm gated_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .out_pol(out_pol),
  .gate_pol(gate_pol), .gate_in(gate_in), .pwm_out(pwm_out)
);

// File: tb/gated_pwm_tb.sv
module gated_pwm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, halt = 1'b0, out_pol = 1'b0;
  logic [1:0]  gate_pol = 2'b00;
  logic        gate_in = 1'b0, tick_src = 1'b0, ext_clk = 1'b0, alt_sel = 1'b0;
  logic [2:0]  div_sel = 3'd0;
  logic [31:0] const_a = 0, const_b = 0, const_a2 = 0, const_b2 = 0;
  logic        pwm_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gated_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .halt(halt), .out_pol(out_pol),
    .gate_pol(gate_pol), .gate_in(gate_in), .tick_src(tick_src), .div_sel(div_sel),
    .ext_clk(ext_clk), .alt_sel(alt_sel), .const_a(const_a), .const_b(const_b),
    .const_a2(const_a2), .const_b2(const_b2), .pwm_out(pwm_out)
  );

  task automatic check_now(string req, bit act);
    logic exp;
    #1;
    exp = act ? out_pol : ~out_pol;
    checks++;
    if (pwm_out !== exp) begin
      errors++;
      $display("FAIL %s: pwm_out=%b expected %b at %0t", req, pwm_out, exp, $time);
    end
  endtask

  task automatic expect_seq(string req, logic [63:0] pat, int n);
    for (int i = 0; i < n; i++) begin
      check_now(req, pat[i]);
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] make_pat(int a, int b, int mult, int n);
    logic [63:0] p = '0;
    int la = (a == 0) ? mult : a * mult;
    int lb = (b == 0) ? mult : b * mult;
    for (int i = 0; i < n; i++) p[i] = ((i % (la + lb)) < la);
    return p;
  endfunction

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_halt();
    @(negedge clk); halt = 1'b1;
    @(negedge clk); halt = 1'b0;
  endtask

  task automatic t_reset();
    check_now("R1", 1'b0);
    @(negedge clk);
    check_now("R1", 1'b0);
  endtask

  task automatic t_basic();
    const_a = 3; const_b = 2; div_sel = 0;
    do_start();
    expect_seq("R2", make_pat(3, 2, 1, 20), 20);
    do_halt();
  endtask

  task automatic t_prescale();
    const_a = 2; const_b = 1; div_sel = 2;
    do_start();
    expect_seq("R3", make_pat(2, 1, 4, 30), 30);
    do_halt();
    div_sel = 0;
  endtask

  task automatic t_zero();
    const_a = 0; const_b = 0;
    do_start();
    expect_seq("R4", make_pat(1, 1, 1, 10), 10);
    do_halt();
  endtask

  task automatic t_pol();
    out_pol = 1'b1; const_a = 1; const_b = 3;
    check_now("R5", 1'b0);
    do_start();
    check_now("R5", 1'b1);
    if (pwm_out !== 1'b1) begin errors++; $display("FAIL R5: pwm_out=%b expected 1", pwm_out); end
    checks++;
    expect_seq("R5", make_pat(1, 3, 1, 12), 12);
    do_halt();
    out_pol = 1'b0;
  endtask

  task automatic t_halt();
    const_a = 3; const_b = 3;
    do_start();
    expect_seq("R6", make_pat(3, 3, 1, 2), 2);
    halt = 1'b1;
    @(negedge clk); halt = 1'b0;
    expect_seq("R6", 64'h0, 6);
    start = 1'b1; halt = 1'b1;
    @(negedge clk); start = 1'b0; halt = 1'b0;
    expect_seq("R6", 64'h0, 4);
    do_start();
    expect_seq("R6", make_pat(3, 3, 1, 8), 8);
    do_halt();
  endtask

  task automatic t_gate_low();
    gate_pol = 2'b01; gate_in = 1'b0; const_a = 4; const_b = 4;
    do_start();
    expect_seq("R7", 64'b11, 2);
    gate_in = 1'b1;
    expect_seq("R7", 64'h0, 5);
    gate_in = 1'b0;
    expect_seq("R7", 64'b1000011, 7);
    do_halt();
    gate_pol = 2'b00;
  endtask

  task automatic t_gate_high();
    gate_pol = 2'b10; gate_in = 1'b0; const_a = 2; const_b = 2;
    do_start();
    expect_seq("R8", 64'h0, 4);
    gate_in = 1'b1;
    expect_seq("R8", make_pat(2, 2, 1, 9), 9);
    do_halt();
    gate_pol = 2'b00; gate_in = 1'b0;
  endtask

  task automatic t_gate_ignored();
    gate_pol = 2'b11; gate_in = 1'b1; const_a = 2; const_b = 2;
    do_start();
    expect_seq("R9", make_pat(2, 2, 1, 8), 8);
    do_halt();
    gate_pol = 2'b00; gate_in = 1'b1;
    do_start();
    expect_seq("R9", make_pat(2, 2, 1, 4), 4);
    gate_in = 1'b0;
    expect_seq("R9", 64'b0011, 4);
    do_halt();
  endtask

  task automatic t_alt();
    const_a = 2; const_b = 2; const_a2 = 5; const_b2 = 1; alt_sel = 1'b0;
    do_start();
    alt_sel = 1'b1;
    expect_seq("R10", 64'b111110111110011, 15);
    do_halt();
    alt_sel = 1'b0;
  endtask

  task automatic ext_edge();
    ext_clk = 1'b1; repeat (4) @(negedge clk);
    ext_clk = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic t_ext();
    tick_src = 1'b1; ext_clk = 1'b0; const_a = 2; const_b = 2;
    repeat (4) @(negedge clk);
    do_start();
    expect_seq("R11", 64'hFFFF, 12);
    ext_edge();
    check_now("R11", 1'b1);
    ext_edge();
    check_now("R11", 1'b0);
    expect_seq("R11", 64'h0, 6);
    ext_edge();
    check_now("R11", 1'b0);
    ext_edge();
    check_now("R11", 1'b1);
    do_halt();
    tick_src = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_prescale();
    t_zero();
    t_pol();
    t_halt();
    t_gate_low();
    t_gate_high();
    t_gate_ignored();
    t_alt();
    t_ext();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule